// File: doc/BRIEF.md
# Watchdog Timer with Interrupt and Reset Modes

This block is a watchdog timer that counts a slow oscillator-rate enable (`osc_tick`) and, when software fails to restart it in time, raises an interrupt, asserts a one-cycle system reset, or does both in sequence. An 8-bit control register, written and read through a plain strobe/data pair, holds an interrupt flag, an interrupt enable, a reset enable, a self-expiring change-enable bit and a 4-bit period select. The period is 2^(BASE_LOG2 + code) enabled ticks. With the default `BASE_LOG2` of 11 this runs from 2048 to 1,048,576 ticks.

The combined mode supports an orderly shutdown. The first time-out only interrupts, and hardware drops the interrupt enable as soon as the CPU takes the vector. The block is then in plain reset mode, and the next time-out resets the system unless software re-arms it. Two inputs protect the configuration. A fuse input forces the block to run whatever software writes. A latched reset-flag input pins the reset enable on until software clears that flag. The reset enable can be cleared, and the period changed, only during the short window that the change-enable bit opens.

Top module: `wdt_core`

## Requirements
- R1: After reset, `rd_data` is 0x00 (bit 3 follows `rst_flag`), `irq` is 0 and `sys_rst` is 0.
- R2: The mode is decoded from {`always_on`, reset enable, interrupt enable}. With `always_on`=0: {0,0} is stopped (no time-outs), {0,1} is interrupt only, {1,0} is reset only, {1,1} is interrupt-then-reset. With `always_on`=1 the reset enable is ignored: interrupt enable 0 gives reset only, and 1 gives interrupt-then-reset.
- R3: Each time-out happens 2^(BASE_LOG2+code) `osc_tick` pulses after the counter was last cleared. Cycles without `osc_tick` do not count. Codes at or above NUM_CODES (10 to 15 by default) behave as code NUM_CODES-1.
- R4: `wd_restart` clears the counter, and no time-out takes effect in the cycle it is high.
- R5: In interrupt-only mode a time-out sets the flag (bit 7), and `irq` = flag AND interrupt enable (bit 6). Writing 1 to bit 7 clears the flag. `irq_ack` clears the flag and leaves the interrupt enable set.
- R6: In reset-only mode a time-out gives a `sys_rst` pulse exactly one cycle long and leaves the flag alone. The counter is held at zero during the pulse, so pulses recur every period+1 enabled ticks.
- R7: In interrupt-then-reset mode a time-out with the flag clear sets the flag and does not reset. A time-out with the flag still set asserts `sys_rst` and leaves the flag set.
- R8: `irq_ack` in interrupt-then-reset mode clears both the flag and the interrupt enable, so the block continues in reset mode.
- R9: Writing 1 to bit 4 sets the change-enable bit, which reads 1 for exactly CE_CYCLES (4) cycles and then clears itself.
- R10: Writing 0 to the reset enable (bit 3), or writing a new period select, takes effect only if change-enable is already 1 at that write. Setting the reset enable, and writing the interrupt enable, need no change-enable.
- R11: While `rst_flag` is 1, bit 3 reads 1 and the stored reset enable is forced to 1. After `rst_flag` falls, the reset enable stays 1 until it is cleared under change-enable.
- R12: Register layout: bit 7 flag, bit 6 interrupt enable, bit 5 period-select MSB, bit 4 change-enable, bit 3 reset enable, bits 2..0 period-select low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Oscillator-rate count enable |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read view |
| wd_restart | input | 1 | Watchdog restart strobe |
| irq_ack | input | 1 | CPU has vectored to the watchdog interrupt |
| always_on | input | 1 | Fuse: forces the watchdog to run |
| rst_flag | input | 1 | Latched watchdog-reset flag |
| irq | output | 1 | Interrupt request |
| sys_rst | output | 1 | One-cycle system reset request |

## Verification
The checker watches several rules on every cycle:
- `sys_rst` never lasts two cycles, and never follows a restart cycle.
- Bit 3 reads 1 whenever `rst_flag` is high.
- The period bits never change across a write made without change-enable.
- Change-enable never stays up past its window.

Exact time-out counts need the bench's scenarios and its cycle-by-cycle reference model. The same holds for the modes and their fuse override, the two-step escalation with and without acknowledge, slow tick rates and reserved period codes.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

   typedef enum logic [1:0] {
      WD_OFF  = 2'd0,
      WD_IRQ  = 2'd1,
      WD_RST  = 2'd2,
      WD_BOTH = 2'd3
   } wd_mode_e;

   localparam int FLAG_POS   = 7;
   localparam int IEN_POS    = 6;
   localparam int SEL_HI_POS = 5;
   localparam int CHG_POS    = 4;
   localparam int REN_POS    = 3;

   function automatic wd_mode_e wd_decode(input logic fuse_run,
                                          input logic ren,
                                          input logic ien);
      wd_mode_e m;
      if (fuse_run)
         m = ien ? WD_BOTH : WD_RST;
      else begin
         case ({ren, ien})
            2'b00:   m = WD_OFF;
            2'b01:   m = WD_IRQ;
            2'b10:   m = WD_RST;
            default: m = WD_BOTH;
         endcase
      end
      return m;
   endfunction

endpackage

// File: rtl/wdt_ctrl_reg.sv
`timescale 1ns/1ps
module wdt_ctrl_reg
   import wdt_pkg::*;
#(
   parameter int CE_CYCLES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       force_ren,
   input  logic       flag_set,
   input  logic       ack,
   input  logic       ack_ien_clr,
   output logic       flag_o,
   output logic       ien_o,
   output logic       ren_o,
   output logic [3:0] sel_o,
   output logic [7:0] rd_o
);

   localparam int             CEW     = $clog2(CE_CYCLES + 1);
   localparam logic [CEW-1:0] CE_LOAD = CEW'(CE_CYCLES - 1);

   initial assert (CE_CYCLES >= 1) else $error("CE_CYCLES must be at least 1");

   logic           flag_q, ien_q, ren_q, chg_q;
   logic [3:0]     sel_q;
   logic [CEW-1:0] chg_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (flag_set)
         flag_q <= 1'b1;
      else if (ack || (wr_en && wr_data[FLAG_POS]))
         flag_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ien_q <= 1'b0;
      else if (ack_ien_clr)
         ien_q <= 1'b0;
      else if (wr_en)
         ien_q <= wr_data[IEN_POS];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ren_q <= 1'b0;
      else if (force_ren)
         ren_q <= 1'b1;
      else if (wr_en) begin
         if (wr_data[REN_POS])
            ren_q <= 1'b1;
         else if (chg_q)
            ren_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel_q <= '0;
      else if (wr_en && chg_q)
         sel_q <= {wr_data[SEL_HI_POS], wr_data[2:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chg_q     <= 1'b0;
         chg_cnt_q <= '0;
      end else if (wr_en && wr_data[CHG_POS]) begin
         chg_q     <= 1'b1;
         chg_cnt_q <= CE_LOAD;
      end else if (chg_q) begin
         if (chg_cnt_q == '0)
            chg_q <= 1'b0;
         else
            chg_cnt_q <= chg_cnt_q - 1'b1;
      end
   end

   always_comb begin
      flag_o = flag_q;
      ien_o  = ien_q;
      ren_o  = ren_q | force_ren;
      sel_o  = sel_q;
      rd_o   = {flag_q, ien_q, sel_q[3], chg_q, ren_q | force_ren, sel_q[2:0]};
   end

endmodule

// File: rtl/wdt_prescaler.sv
`timescale 1ns/1ps
module wdt_prescaler #(
   parameter int BASE_LOG2 = 11,
   parameter int NUM_CODES = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       tick,
   input  logic       restart,
   input  logic       hold_clr,
   input  logic [3:0] sel,
   output logic       expire
);

   localparam int         CW      = BASE_LOG2 + NUM_CODES - 1;
   localparam logic [4:0] NC      = 5'(NUM_CODES);
   localparam logic [3:0] TOP_SEL = 4'(NUM_CODES - 1);

   initial begin
      assert (BASE_LOG2 >= 1) else $error("BASE_LOG2 must be at least 1");
      assert (NUM_CODES >= 1 && NUM_CODES <= 16) else $error("NUM_CODES must be 1..16");
   end

   logic [CW-1:0]        cnt_q;
   logic [NUM_CODES-1:0] at_end;
   logic [3:0]           sel_eff;

   // one terminal detector per period code: low bits all ones
   for (genvar k = 0; k < NUM_CODES; k++) begin : g_term
      assign at_end[k] = &cnt_q[BASE_LOG2+k-1:0];
   end

   always_comb begin
      sel_eff = ({1'b0, sel} >= NC) ? TOP_SEL : sel;
      expire  = run && tick && !restart && !hold_clr && at_end[sel_eff];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart || hold_clr || expire)
         cnt_q <= '0;
      else if (run && tick)
         cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
module wdt_core
   import wdt_pkg::*;
#(
   parameter int BASE_LOG2 = 11,
   parameter int NUM_CODES = 10,
   parameter int CE_CYCLES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       osc_tick,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   output logic [7:0] rd_data,
   input  logic       wd_restart,
   input  logic       irq_ack,
   input  logic       always_on,
   input  logic       rst_flag,
   output logic       irq,
   output logic       sys_rst
);

   wd_mode_e   mode;
   logic       flag, ien, ren, expire;
   logic       flag_set, rst_req, ack_ien_clr;
   logic [3:0] sel;
   logic       sys_rst_q;

   wdt_ctrl_reg #(.CE_CYCLES(CE_CYCLES)) u_reg (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .force_ren   (rst_flag),
      .flag_set    (flag_set),
      .ack         (irq_ack),
      .ack_ien_clr (ack_ien_clr),
      .flag_o      (flag),
      .ien_o       (ien),
      .ren_o       (ren),
      .sel_o       (sel),
      .rd_o        (rd_data)
   );

   wdt_prescaler #(.BASE_LOG2(BASE_LOG2), .NUM_CODES(NUM_CODES)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (mode != WD_OFF),
      .tick     (osc_tick),
      .restart  (wd_restart),
      .hold_clr (sys_rst_q),
      .sel      (sel),
      .expire   (expire)
   );

   always_comb begin
      mode        = wd_decode(always_on, ren, ien);
      flag_set    = expire && ((mode == WD_IRQ) || (mode == WD_BOTH && !flag));
      rst_req     = expire && ((mode == WD_RST) || (mode == WD_BOTH && flag));
      ack_ien_clr = irq_ack && (mode == WD_BOTH);
      irq         = flag && ien;
      sys_rst     = sys_rst_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sys_rst_q <= 1'b0;
      else
         sys_rst_q <= rst_req;
   end

endmodule

// File: rtl/wdt_core_chk.sv
`timescale 1ns/1ps
module wdt_core_chk #(
   parameter int CE_CYCLES = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [7:0] wr_data,
   input logic       wd_restart,
   input logic       rst_flag,
   input logic [7:0] rd_data,
   input logic       sys_rst
);

   int chg_age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         chg_age <= 0;
      else if (wr_en && wr_data[4])
         chg_age <= 1;
      else if (rd_data[4])
         chg_age <= chg_age + 1;
      else
         chg_age <= 0;
   end

   // R6
   rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst |=> !sys_rst);

   // R4
   restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wd_restart |=> !sys_rst);

   // R11
   flag_pins_ren_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_flag |-> rd_data[3]);

   // R10
   sel_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rd_data[4]) |=>
         ({rd_data[5], rd_data[2:0]} == $past({rd_data[5], rd_data[2:0]})));

   // R9
   chg_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[4] |-> (chg_age <= CE_CYCLES));

endmodule

bind wdt_core wdt_core_chk #(.CE_CYCLES(CE_CYCLES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .wd_restart (wd_restart),
   .rst_flag   (rst_flag),
   .rd_data    (rd_data),
   .sys_rst    (sys_rst)
);

// File: tb/wdt_core_test.sv
`timescale 1ns/1ps
module wdt_core_test;

   localparam int B   = 3;
   localparam int NC  = 10;
   localparam int CEC = 4;

   logic       clk = 1'b0, rst_n = 1'b0, osc_tick = 1'b1;
   logic       wr_en = 1'b0, kick = 1'b0, ack = 1'b0, aon = 1'b0, rflag = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd;
   logic       irq, srst;

   int checks = 0, errors = 0;
   bit slow = 1'b0;
   int tcnt = 0;

   wdt_core #(.BASE_LOG2(B), .NUM_CODES(NC), .CE_CYCLES(CEC)) uut (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd), .wd_restart(kick), .irq_ack(ack), .always_on(aon),
      .rst_flag(rflag), .irq(irq), .sys_rst(srst)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      #5;
      tcnt++;
      osc_tick = !slow || (tcnt % 2 == 0);
   end

   // behavioural reference model
   int m_cnt = 0, m_sel = 0, m_age = 0;
   bit m_flag = 0, m_ie = 0, m_re = 0, m_ce = 0, m_srst = 0;
   int mode, code, per;
   bit to, nf, ni, nr, nce, ns;
   int nsel, nage, ncnt;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_sel = 0; m_age = 0;
         m_flag = 0; m_ie = 0; m_re = 0; m_ce = 0; m_srst = 0;
      end else begin
         if (aon) mode = m_ie ? 3 : 2;
         else     mode = ((m_re || rflag) ? 2 : 0) + (m_ie ? 1 : 0);
         code = (m_sel >= NC) ? NC - 1 : m_sel;
         per  = 1 << (B + code);
         to   = (mode != 0) && osc_tick && !kick && !m_srst && (m_cnt % per == per - 1);
         nf = m_flag;
         if (wr_en && wr_data[7]) nf = 0;
         if (ack) nf = 0;
         if (to && (mode == 1 || (mode == 3 && !m_flag))) nf = 1;
         ni = m_ie;
         if (wr_en) ni = wr_data[6];
         if (ack && mode == 3) ni = 0;
         nr = m_re;
         if (rflag) nr = 1;
         else if (wr_en) begin
            if (wr_data[3]) nr = 1;
            else if (m_ce) nr = 0;
         end
         nsel = m_sel;
         if (wr_en && m_ce) nsel = (wr_data[5] ? 8 : 0) + int'(wr_data[2:0]);
         nce = m_ce; nage = m_age;
         if (wr_en && wr_data[4]) begin nce = 1; nage = 0; end
         else if (m_ce) begin
            nage = m_age + 1;
            if (nage >= CEC) nce = 0;
         end
         if (kick || m_srst || to) ncnt = 0;
         else if (mode != 0 && osc_tick) ncnt = m_cnt + 1;
         else ncnt = m_cnt;
         ns = to && (mode == 2 || (mode == 3 && m_flag));
         m_flag = nf; m_ie = ni; m_re = nr; m_sel = nsel; m_ce = nce; m_age = nage;
         m_cnt = ncnt; m_srst = ns;
      end
   end

   function automatic logic [7:0] exp_rd();
      logic [3:0] s = m_sel[3:0];
      return {m_flag, m_ie, s[3], m_ce, m_re | rflag, s[2:0]};
   endfunction

   always @(negedge clk) begin
      checks++;
      if (rd !== exp_rd()) begin
         errors++;
         $display("FAIL R12 rd_data per-cycle actual=%02h expected=%02h", rd, exp_rd());
      end
      checks++;
      if (irq !== (m_flag && m_ie)) begin
         errors++;
         $display("FAIL R5 irq per-cycle actual=%0b expected=%0b", irq, m_flag && m_ie);
      end
      checks++;
      if (srst !== m_srst) begin
         errors++;
         $display("FAIL R6 sys_rst per-cycle actual=%0b expected=%0b", srst, m_srst);
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #5;
   endtask

   task automatic step(input bit w, input logic [7:0] d, input bit k, input bit a);
      wr_en = w; wr_data = d; kick = k; ack = a;
      cyc(1);
      wr_en = 0; kick = 0; ack = 0;
   endtask

   task automatic wait_for(input bit use_rst, input int lim, output int n, output bit seen);
      n = 0; seen = 0;
      while (!seen && n < lim) begin
         cyc(1);
         n++;
         seen = use_rst ? srst : irq;
      end
   endtask

   int n, m;
   bit seen;

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1;
      cyc(1);
      chk("R1 reset rd_data", rd, 0);
      chk("R1 reset irq", irq, 0);
      chk("R1 reset sys_rst", srst, 0);
      cyc(50);
      chk("R2 stopped mode stays idle", {srst, rd}, 0);

      step(1, 8'h40, 0, 0);
      wait_for(0, 100, n, seen);
      chk("R3 code0 interrupt period", n, 8);
      chk("R5 flag and enable set", rd, 8'hC0);
      step(1, 8'hC0, 0, 0);
      chk("R5 write-one clears flag", rd, 8'h40);
      wait_for(0, 100, n, seen);
      step(0, 8'h00, 0, 1);
      chk("R5 ack keeps enable in interrupt mode", rd, 8'h40);

      step(1, 8'h43, 0, 0);
      chk("R10 period locked without change-enable", rd & 8'h2F, 0);
      step(1, 8'h50, 0, 0);
      chk("R9 change-enable set", rd[4], 1);
      step(1, 8'h43, 0, 0);
      chk("R10 period written under change-enable", rd & 8'h27, 3);
      cyc(2);
      chk("R9 change-enable still set in 4th cycle", rd[4], 1);
      cyc(1);
      chk("R9 change-enable cleared after 4 cycles", rd[4], 0);

      step(1, 8'hC3, 1, 0);
      wait_for(0, 200, n, seen);
      chk("R3 code3 interrupt period", n, 64);

      step(1, 8'hC3, 1, 0);
      repeat (4) begin
         cyc(50);
         step(0, 8'h00, 1, 0);
      end
      chk("R4 restarts prevent time-out", rd[7], 0);

      step(1, 8'h50, 0, 0);
      step(1, 8'hE7, 1, 0);
      chk("R12 reserved code stored as written", rd & 8'h27, 8'h27);
      wait_for(0, 5000, n, seen);
      chk("R3 reserved code acts as longest", n, 4096);

      slow = 1;
      step(1, 8'h50, 0, 0);
      step(1, 8'hC0, 1, 0);
      wait_for(0, 100, n, seen);
      chk("R3 half-rate ticks double period", (n >= 15 && n <= 16) ? 1 : 0, 1);
      slow = 0;

      step(1, 8'h50, 0, 0);
      step(1, 8'h88, 1, 0);
      wait_for(1, 100, n, seen);
      chk("R6 reset mode period", n, 8);
      wait_for(1, 100, m, seen);
      chk("R6 pulse spacing period+1", m, 9);
      cyc(1);
      chk("R6 pulse one cycle", srst, 0);
      chk("R6 flag untouched", rd[7], 0);

      step(1, 8'hC8, 1, 0);
      wait_for(0, 100, n, seen);
      chk("R7 first time-out interrupts", n, 8);
      chk("R7 no reset on first time-out", {srst, rd}, 9'h0C8);
      step(0, 8'h00, 0, 1);
      chk("R8 ack clears flag and enable", rd, 8'h08);
      wait_for(1, 20, n, seen);
      chk("R8 continues in reset mode", n, 7);

      step(1, 8'hC8, 1, 0);
      wait_for(0, 100, n, seen);
      wait_for(1, 100, n, seen);
      chk("R7 unserviced second time-out resets", n, 8);
      chk("R7 flag stays set", rd[7], 1);

      step(1, 8'h00, 0, 0);
      chk("R10 reset enable kept without change-enable", rd[3], 1);
      step(1, 8'h10, 0, 0);
      step(1, 8'h80, 0, 0);
      chk("R10 reset enable cleared under change-enable", rd[3], 0);

      rflag = 1;
      cyc(1);
      chk("R11 reset flag forces bit3", rd[3], 1);
      step(1, 8'h10, 0, 0);
      step(1, 8'h00, 0, 0);
      chk("R11 cannot clear while flag high", rd[3], 1);
      rflag = 0;
      cyc(1);
      chk("R11 reset enable held after flag drops", rd[3], 1);
      step(1, 8'h10, 0, 0);
      step(1, 8'h00, 0, 0);
      chk("R11 clearable after flag drops", rd[3], 0);

      aon = 1;
      step(1, 8'h80, 1, 0);
      wait_for(1, 100, n, seen);
      chk("R2 fuse forces reset mode", n, 8);
      step(1, 8'hC0, 1, 0);
      wait_for(0, 100, n, seen);
      chk("R2 fuse with enable gives interrupt first", {srst, 7'(n)}, 8);
      step(0, 8'h00, 0, 1);
      chk("R8 ack under fuse drops enable", rd[6], 0);
      aon = 0;
      step(1, 8'h80, 1, 0);
      wait_for(1, 200, n, seen);
      chk("R2 stopped after fuse released", seen, 0);

      step(1, 8'h10, 0, 0);
      step(1, 8'h21, 0, 0);
      chk("R12 layout period MSB bit5 low bits 2..0", rd, 8'h31);

      cyc(2);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule